// File: doc/BRIEF.md
# Page Hamming ECC accumulator

This block sits beside the data path of a NAND flash controller and computes Hamming parity over a 512-byte page while the page is being moved. The page is split into two 256-byte halves, and each half gets its own code. Each code has 16 line-parity bits, taken over the byte index, and 6 column-parity bits, taken over the bit position. The controller steers the engine with three mode codes written to its mode port. One code clears all state, one starts accumulating over the bytes that follow, and one switches the result port to readout.

In readout the six parity bytes come out as three 16-bit words in a fixed interleaved order. A consumer that keeps reading sees the sequence start again at the first word. The byte input never stalls: `in_ready` is tied high, and a byte is taken on any cycle where `in_valid` is high. The result port follows valid/ready rules. `res_valid` stays high for as long as readout mode is active. `res_word` holds its value until a cycle in which `res_ready` is also high, and the next word appears on the cycle after that.

Top module: `ecc_page_acc`

## Requirements
- R1: Writing mode code 0xF4 clears both halves' parity and the byte counter, so an immediate readout returns 0xFFFF in all three words. The same holds after power-on reset.
- R2: Bytes offered while the engine is not in calculate mode (after 0xF4, after any code other than 0xB4 or 0xD4, or during readout) change neither the parity nor the byte count. This includes a dummy byte sent right after 0xF4.
- R3: After mode code 0xB4, bytes 0 to 255 feed the first half's code and bytes 256 to 511 feed the second half's code.
- R4: Line parity bit 2k (k = 0..7) is the XOR of the bit-parity of every byte whose in-half index has bit k equal to 0. Bit 2k+1 covers the bytes whose index bit k is 1.
- R5: Column parity bit 2k (k = 0..2) is the XOR, over all bytes of the half, of the data bits whose position has bit k equal to 0. Bit 2k+1 covers the positions where bit k is 1. The column byte is {~CP5..~CP0, 2'b11}.
- R6: All parity bits are output inverted. A half of all-0xFF bytes gives 0xFF in all three of its bytes.
- R7: After mode code 0xD4 the words are read out in this order. Word 0 is {half0 LP15..8, half0 LP7..0}. Word 1 is {half1 LP7..0, half0 CP byte}. Word 2 is {half1 CP byte, half1 LP15..8}. In each pair the first byte is the high byte.
- R8: A fourth accepted read returns word 0 again, and the cycle repeats.
- R9: Bytes beyond the 512th in calculate mode are ignored.
- R10: `in_ready` is always 1. `res_valid` is high only in readout mode, and `res_word` is stable while `res_valid` is high and `res_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode write strobe |
| mode_val | input | 8 | Mode code (0xF4 clear, 0xB4 calculate, 0xD4 readout) |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Always 1; the byte port never stalls |
| in_byte | input | 8 | Data byte being transferred |
| res_valid | output | 1 | Result word available (readout mode) |
| res_ready | input | 1 | Consumer accepts the current word |
| res_word | output | 16 | Current result word |

## Verification
The checker assumes three things about the inputs. A mode write is never sent in the same cycle as a data byte. The byte counter moves only while calculate mode is active. A held result word can change only through a mode write or an accepted read. The stimulus meets these assumptions by giving every mode write, byte and read its own cycle, and by lowering each strobe before the next one is raised. Each page is preceded by a clear code and a dummy byte. The page patterns are uniform fills, index-derived fills, a scrambled fill, a single flipped bit swept over every bit position at the edges of both halves, and an overlong page of 600 bytes.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam logic [7:0] MODE_CLR  = 8'hF4;
  localparam logic [7:0] MODE_CALC = 8'hB4;
  localparam logic [7:0] MODE_READ = 8'hD4;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_READ} ecc_state_t;
endpackage

// File: rtl/ecc_half_acc.sv
// One 256-byte (2**IDX_W) Hamming accumulator; IDX_W must be 8 or less.
module ecc_half_acc #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [7:0]       lp_lo_n,
  output logic [7:0]       lp_hi_n,
  output logic [7:0]       cp_n
);
  logic [15:0] lp_q;
  logic [15:0] lp_hit;
  logic [7:0]  col_q;
  logic [5:0]  cp;
  logic        par;

  assign par = ^data;

  // each index bit steers the byte parity into its even or odd line bit
  for (genvar k = 0; k < 8; k++) begin : g_line
    if (k < IDX_W) begin : g_used
      assign lp_hit[2*k]   = par & ~idx[k];
      assign lp_hit[2*k+1] = par &  idx[k];
    end else begin : g_unused
      assign lp_hit[2*k]   = 1'b0;
      assign lp_hit[2*k+1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (en) begin
      lp_q  <= lp_q ^ lp_hit;
      col_q <= col_q ^ data;
    end
  end

  // column parity folded from the per-position XOR of all bytes
  always_comb begin
    cp = '0;
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 3; k++) begin
        cp[2*k + ((b >> k) & 1)] = cp[2*k + ((b >> k) & 1)] ^ col_q[b];
      end
    end
  end

  assign lp_lo_n = ~lp_q[7:0];
  assign lp_hi_n = ~lp_q[15:8];
  assign cp_n    = {~cp, 2'b11};
endmodule

// File: rtl/ecc_result_seq.sv
module ecc_result_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        adv,
  input  logic [7:0]  a_lo,
  input  logic [7:0]  a_hi,
  input  logic [7:0]  a_cp,
  input  logic [7:0]  b_lo,
  input  logic [7:0]  b_hi,
  input  logic [7:0]  b_cp,
  output logic [15:0] word
);
  logic [1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) ptr_q <= 2'd0;
    else if (adv)          ptr_q <= (ptr_q == 2'd2) ? 2'd0 : ptr_q + 2'd1;
  end

  always_comb begin
    case (ptr_q)
      2'd0:    word = {a_hi, a_lo};
      2'd1:    word = {b_lo, a_cp};
      default: word = {b_cp, b_hi};
    endcase
  end
endmodule

// File: rtl/ecc_page_acc.sv
module ecc_page_acc
  import ecc_pkg::*;
#(
  parameter int HALF_LOG2 = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_val,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [15:0] res_word
);
  localparam int CNT_W      = HALF_LOG2 + 2;
  localparam int PAGE_BYTES = 2 ** (HALF_LOG2 + 1);

  ecc_state_t       state_q;
  logic [CNT_W-1:0] byte_cnt;
  logic             calc_on;
  logic             take;
  logic             clr;
  logic [7:0]       lo_n [2];
  logic [7:0]       hi_n [2];
  logic [7:0]       cpb_n [2];

  assign calc_on   = (state_q == ST_CALC);
  assign take      = calc_on && in_valid && (byte_cnt < CNT_W'(PAGE_BYTES));
  assign clr       = mode_we && (mode_val == MODE_CLR);
  assign in_ready  = 1'b1;
  assign res_valid = (state_q == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (mode_we) begin
      case (mode_val)
        MODE_CALC: state_q <= ST_CALC;
        MODE_READ: state_q <= ST_READ;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) byte_cnt <= '0;
    else if (take)     byte_cnt <= byte_cnt + 1'b1;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    ecc_half_acc #(.IDX_W(HALF_LOG2)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .en      (take && (byte_cnt[HALF_LOG2] == 1'(h))),
      .idx     (byte_cnt[HALF_LOG2-1:0]),
      .data    (in_byte),
      .lp_lo_n (lo_n[h]),
      .lp_hi_n (hi_n[h]),
      .cp_n    (cpb_n[h])
    );
  end

  ecc_result_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (mode_we && (mode_val == MODE_READ)),
    .adv     (res_valid && res_ready),
    .a_lo    (lo_n[0]),
    .a_hi    (hi_n[0]),
    .a_cp    (cpb_n[0]),
    .b_lo    (lo_n[1]),
    .b_hi    (hi_n[1]),
    .b_cp    (cpb_n[1]),
    .word    (res_word)
  );
endmodule

// File: rtl/ecc_page_chk.sv
module ecc_page_chk #(
  parameter int CNT_W      = 10,
  parameter int PAGE_BYTES = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [7:0]       mode_val,
  input logic             in_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [15:0]      res_word,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             calc_on
);
  assert_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !mode_we) |=> (res_valid && $stable(res_word)));

  assert_valid_after_read_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(mode_we && mode_val == 8'hD4));

  assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(PAGE_BYTES));

  assert_clear_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_val == 8'hF4) |=> (byte_cnt == '0));

  assert_no_count_outside_calc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!calc_on && !mode_we) |=> $stable(byte_cnt));
endmodule

bind ecc_page_acc ecc_page_chk #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_we   (mode_we),
  .mode_val  (mode_val),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_word  (res_word),
  .byte_cnt  (byte_cnt),
  .calc_on   (calc_on)
);

// File: tb/test_ecc_page_acc.sv
module test_ecc_page_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_val = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_word;

  int vecs = 0;
  int errs = 0;
  logic [7:0]  pg [0:599];
  logic [15:0] exp_w [0:2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_page_acc i_ecc_page_acc (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    vecs++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic put_mode(input logic [7:0] c);
    @(negedge clk); mode_we = 1'b1; mode_val = c;
    @(posedge clk); #1 mode_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic get_word(input string tag, input logic [15:0] expv);
    @(negedge clk);
    check({tag, " R10 valid"}, {15'd0, res_valid}, 16'd1);
    check(tag, res_word, expv);
    res_ready = 1'b1;
    @(posedge clk); #1 res_ready = 1'b0;
  endtask

  // R4 R5 R6 R7: expected words from the first 512 bytes of pg
  task automatic model();
    logic [15:0] lp;
    logic [7:0]  col, lo [2], hi [2], cb [2];
    logic [5:0]  cp;
    for (int h = 0; h < 2; h++) begin
      lp = '0; col = '0;
      for (int i = 0; i < 256; i++) begin
        col ^= pg[h*256+i];
        for (int k = 0; k < 8; k++)
          if ((i >> k) & 1) lp[2*k+1] ^= ^pg[h*256+i];
          else              lp[2*k]   ^= ^pg[h*256+i];
      end
      cp[0] = col[0]^col[2]^col[4]^col[6];
      cp[1] = col[1]^col[3]^col[5]^col[7];
      cp[2] = col[0]^col[1]^col[4]^col[5];
      cp[3] = col[2]^col[3]^col[6]^col[7];
      cp[4] = ^col[3:0];
      cp[5] = ^col[7:4];
      lo[h] = ~lp[7:0]; hi[h] = ~lp[15:8]; cb[h] = {~cp, 2'b11};
    end
    exp_w[0] = {hi[0], lo[0]};
    exp_w[1] = {lo[1], cb[0]};
    exp_w[2] = {cb[1], hi[1]};
  endtask

  // R1 R2 R3: clear, dummy byte, calculate, then R7 R8 readout
  task automatic run_page(input int n, input string tag);
    put_mode(8'hF4);
    put_byte(8'h5A);
    put_mode(8'hB4);
    for (int i = 0; i < n; i++) put_byte(pg[i]);
    put_mode(8'hD4);
    model();
    get_word({tag, " R7 w0"}, exp_w[0]);
    get_word({tag, " R7 w1"}, exp_w[1]);
    get_word({tag, " R7 w2"}, exp_w[2]);
    get_word({tag, " R8 wrap"}, exp_w[0]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : stim
    int idxs [7] = '{0, 1, 127, 255, 256, 300, 511};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset res_valid", {15'd0, res_valid}, 16'd0);
    check("R10 in_ready", {15'd0, in_ready}, 16'd1);

    // R1: power-on state reads as all ones
    put_mode(8'hD4);
    get_word("R1 reset w0", 16'hFFFF);
    get_word("R1 reset w1", 16'hFFFF);
    get_word("R1 reset w2", 16'hFFFF);

    // R6: all 0xFF
    for (int i = 0; i < 600; i++) pg[i] = 8'hFF;
    run_page(512, "R6 allFF");
    // R10: word held while not accepted
    put_mode(8'hD4);
    @(negedge clk); check("R10 hold a", res_word, exp_w[0]);
    @(negedge clk); check("R10 hold b", res_word, exp_w[0]);

    for (int i = 0; i < 600; i++) pg[i] = 8'h00;
    run_page(512, "R3 all00");
    for (int i = 0; i < 600; i++) pg[i] = 8'(i);
    run_page(512, "R4 index");
    for (int i = 0; i < 600; i++) pg[i] = 8'((i * 37 + 11) ^ (i >> 3));
    run_page(512, "R5 scramble");
    for (int i = 0; i < 600; i++) pg[i] = (i < 256) ? 8'h00 : 8'hFF;
    run_page(512, "R3 halves");

    // R2: bytes in readout and idle modes are ignored
    for (int i = 0; i < 5; i++) put_byte(8'h13 + 8'(i));
    put_mode(8'h94);
    for (int i = 0; i < 5; i++) put_byte(8'hC1 + 8'(i));
    put_mode(8'hD4);
    get_word("R2 ignored w0", exp_w[0]);
    get_word("R2 ignored w1", exp_w[1]);
    get_word("R2 ignored w2", exp_w[2]);

    // R9: overlong page, tail differs
    for (int i = 0; i < 600; i++) pg[i] = (i < 512) ? 8'(i * 3) : 8'(i ^ 8'hA5);
    run_page(600, "R9 overlong");

    // R4 R5: single flipped bit at each bit position, edges of both halves
    for (int j = 0; j < 7; j++) begin
      for (int b = 0; b < 8; b++) begin
        for (int i = 0; i < 600; i++) pg[i] = 8'hFF;
        pg[idxs[j]][b] = 1'b0;
        run_page(512, $sformatf("R4 R5 flip i%0d b%0d", idxs[j], b));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule